// File: doc/BRIEF.md
# Misprediction-Driven Fetch Gating Controller

This controller saves energy in a speculative pipeline by pausing instruction fetch after branch mispredictions have piled up. The execute stage sends a resolve strobe with a mispredict flag. The controller keeps a saturating count of mispredicted branches. When that count rises above a programmed threshold, it drops the fetch enable to the fetch stage for a programmed number of cycles.

Software programs the threshold and the hold length before operation, and may change them later. A hold length of zero turns gating off. The count is cleared when a hold starts, so a fresh run of mispredictions is needed to start another one. Mispredictions that resolve during a hold still add to the count, but they never lengthen the current hold.

Top module: `fetch_gate_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears the miss count and the hold timer, sets `fetch_en` to 1 and sets `gating` to 0, and it also ends a hold that is in progress.
- R2: A miss event is a cycle with `rs_valid`=1 and `rs_miss`=1. Only a miss event adds one to the count. A correctly predicted branch (`rs_valid`=1, `rs_miss`=0) leaves the count unchanged, and so does `rs_miss` while `rs_valid` is 0.
- R3: A hold starts on a miss event outside a hold when the count after the increment is strictly greater than `cfg_thresh`. `fetch_en` falls in the cycle after that miss event, because it is a registered output.
- R4: A hold keeps `fetch_en` at 0 for exactly the number of cycles in `cfg_len`, and then `fetch_en` returns to 1.
- R5: The count is cleared to zero when a hold starts, so more than `cfg_thresh` new miss events are needed before the next hold.
- R6: Miss events during a hold add to the count, but they neither extend nor restart the hold.
- R7: When `cfg_len` is 0, no hold ever starts and `fetch_en` stays at 1, while miss events are still counted.
- R8: The count saturates at 2^CNT_W-1 and never wraps. With `cfg_thresh` equal to that maximum, no hold ever starts.
- R9: `gating` is 1 exactly in the cycles where `fetch_en` is 0.
- R10: `cfg_len` is captured when a hold starts. Changing it during a hold does not change how long that hold lasts.
- R11: A count left above `cfg_thresh` by miss events during a hold starts a new hold on the first miss event after the hold ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_miss | input | 1 | The resolving branch was mispredicted |
| cfg_thresh | input | CNT_W | Miss threshold; a hold needs a count strictly greater than this |
| cfg_len | input | LEN_W | Hold length in cycles; 0 disables gating |
| fetch_en | output | 1 | Registered fetch enable to the fetch stage |
| gating | output | 1 | High while a hold is in progress |

## Verification
The assertions assume that `rs_miss` matters only when `rs_valid` is high. They also assume that both configuration inputs are sampled at the clock edge like any other input, so they may change in any cycle. They are switched off in reset cycles. The stimulus changes every input, configuration included, only on the falling clock edge. The random phase reprograms the threshold and the hold length in the middle of holds, which exercises the rule that a hold keeps the length it captured at its start.

// File: rtl/fgc_pkg.sv
package fgc_pkg;

    localparam int DEF_CNT_W = 4;
    localparam int DEF_LEN_W = 6;

    // Controller phase: fetching normally or holding fetch off
    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_HOLD  = 1'b1
    } phase_e;

    // One branch resolution report from the execute stage
    typedef struct packed {
        logic valid;
        logic miss;
    } resolve_t;

    function automatic logic is_miss(resolve_t r);
        return r.valid & r.miss;
    endfunction

endpackage

// File: rtl/fgc_miss_counter.sv
module fgc_miss_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    input  logic             clear,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] bumped
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] count_nxt;

    // Saturating increment, never wraps
    assign bumped = (count == CNT_MAX) ? CNT_MAX : count + CNT_ONE;

    always_comb begin
        if (clear)
            count_nxt = '0;
        else if (bump)
            count_nxt = bumped;
        else
            count_nxt = count;
    end

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else
            count <= count_nxt;
    end
endmodule

// File: rtl/fgc_gate_timer.sv
module fgc_gate_timer #(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    output logic [LEN_W-1:0] remain,
    output logic             fetch_en
);
    localparam logic [LEN_W-1:0] LEN_ONE = {{(LEN_W-1){1'b0}}, 1'b1};

    logic [LEN_W-1:0] remain_nxt;

    always_comb begin
        if (load)
            remain_nxt = load_len;
        else if (remain != '0)
            remain_nxt = remain - LEN_ONE;
        else
            remain_nxt = '0;
    end

    // Fetch enable is a flop of its own, set from the next timer value
    always_ff @(posedge clk) begin
        if (rst) begin
            remain   <= '0;
            fetch_en <= 1'b1;
        end else begin
            remain   <= remain_nxt;
            fetch_en <= (remain_nxt == '0);
        end
    end
endmodule

// File: rtl/fgc_trigger.sv
module fgc_trigger
    import fgc_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int LEN_W = 6
) (
    input  resolve_t         ev,
    input  logic             hold,
    input  logic [CNT_W-1:0] bumped,
    input  logic [CNT_W-1:0] thresh,
    input  logic [LEN_W-1:0] len,
    output logic             start
);
    // A hold starts only on a miss outside a hold, with a nonzero
    // length and a post-increment count strictly above the threshold
    assign start = is_miss(ev) && !hold && (len != '0) && (bumped > thresh);
endmodule

// File: rtl/fetch_gate_ctrl.sv
module fetch_gate_ctrl
    import fgc_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter int LEN_W = DEF_LEN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rs_valid,
    input  logic             rs_miss,
    input  logic [CNT_W-1:0] cfg_thresh,
    input  logic [LEN_W-1:0] cfg_len,
    output logic             fetch_en,
    output logic             gating
);
    resolve_t         ev;
    phase_e           phase;
    logic             miss_ev;
    logic             start;
    logic             fe_q;
    logic [CNT_W-1:0] miss_cnt;
    logic [CNT_W-1:0] miss_bumped;
    logic [LEN_W-1:0] remain;

    assign ev.valid = rs_valid;
    assign ev.miss  = rs_miss;
    assign miss_ev  = is_miss(ev);

    fgc_miss_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .bump   (miss_ev),
        .clear  (start),
        .count  (miss_cnt),
        .bumped (miss_bumped)
    );

    fgc_trigger #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_trig (
        .ev     (ev),
        .hold   (gating),
        .bumped (miss_bumped),
        .thresh (cfg_thresh),
        .len    (cfg_len),
        .start  (start)
    );

    fgc_gate_timer #(.LEN_W(LEN_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .load_len (cfg_len),
        .remain   (remain),
        .fetch_en (fe_q)
    );

    assign phase    = (remain != '0) ? PH_HOLD : PH_FETCH;
    assign gating   = (phase == PH_HOLD);
    assign fetch_en = fe_q;
endmodule

// File: rtl/fgc_checker.sv
module fgc_checker #(
    parameter int CNT_W = 4,
    parameter int LEN_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             rs_valid,
    input logic             rs_miss,
    input logic [CNT_W-1:0] cfg_thresh,
    input logic [LEN_W-1:0] cfg_len,
    input logic             fetch_en,
    input logic             gating,
    input logic [CNT_W-1:0] miss_cnt,
    input logic [LEN_W-1:0] remain
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [CNT_W-1:0] sat_next;
    logic             exp_start;

    assign sat_next  = (miss_cnt == CMAX) ? CMAX : miss_cnt + 1'b1;
    assign exp_start = rs_valid && rs_miss && (remain == '0) &&
                       (cfg_len != '0) && (sat_next > cfg_thresh);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (fetch_en && !gating && miss_cnt == '0 && remain == '0)); // R1

    AST_HIT_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
        !(rs_valid && rs_miss) |=> $stable(miss_cnt)); // R2

    AST_START_FETCH_OFF: assert property (@(posedge clk) disable iff (rst)
        exp_start |=> (!fetch_en && remain == $past(cfg_len))); // R3

    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (rst)
        exp_start |=> (miss_cnt == '0)); // R5

    AST_HOLD_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
        (remain != '0) |=> (remain == $past(remain) - 1'b1)); // R6

    AST_HOLD_STILL_COUNTS: assert property (@(posedge clk) disable iff (rst)
        (remain != '0 && rs_valid && rs_miss) |=> (miss_cnt == $past(sat_next))); // R6

    AST_ZERO_LEN_OPEN: assert property (@(posedge clk) disable iff (rst)
        (cfg_len == '0 && fetch_en) |=> fetch_en); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (miss_cnt == CMAX && remain != '0) |=> (miss_cnt == CMAX)); // R8

    AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
        gating == !fetch_en); // R9
endmodule

bind fetch_gate_ctrl fgc_checker #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_fgc_chk (
    .clk        (clk),
    .rst        (rst),
    .rs_valid   (rs_valid),
    .rs_miss    (rs_miss),
    .cfg_thresh (cfg_thresh),
    .cfg_len    (cfg_len),
    .fetch_en   (fetch_en),
    .gating     (gating),
    .miss_cnt   (miss_cnt),
    .remain     (remain)
);

// File: tb/fetch_gate_ctrl_test.sv
module fetch_gate_ctrl_test;
    localparam int CW   = 4;
    localparam int LW   = 6;
    localparam int CMAX = (1 << CW) - 1;

    // Rows: threshold, hold length, consecutive misses, expected cycles with fetch off
    localparam int TBL [12][4] = '{
        '{0, 3, 1, 3}, '{2, 4, 3, 4}, '{2, 4, 2, 0}, '{5, 1, 6, 1},
        '{3, 0, 8, 0}, '{1, 6, 4, 6}, '{15, 8, 20, 0}, '{4, 10, 5, 10},
        '{0, 1, 2, 1}, '{0, 1, 3, 2}, '{7, 2, 7, 0}, '{1, 2, 5, 4}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rs_valid = 1'b0;
    logic          rs_miss = 1'b0;
    logic [CW-1:0] thr = '0;
    logic [LW-1:0] len = '0;
    logic          fetch_en;
    logic          gating;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int mm = 0;
    int rem = 0;

    always #5 clk = ~clk;

    fetch_gate_ctrl #(.CNT_W(CW), .LEN_W(LW)) uut (
        .clk        (clk),
        .rst        (rst),
        .rs_valid   (rs_valid),
        .rs_miss    (rs_miss),
        .cfg_thresh (thr),
        .cfg_len    (len),
        .fetch_en   (fetch_en),
        .gating     (gating)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference model built from the requirements, advanced once per edge
    task automatic model_step(bit v, bit m);
        int  nxt;
        bit  st;
        nxt = (mm == CMAX) ? CMAX : mm + 1;
        st  = v && m && (rem == 0) && (int'(len) != 0) && (nxt > int'(thr));
        if (st) begin
            mm  = 0;
            rem = int'(len);
        end else begin
            if (v && m) mm = nxt;
            if (rem != 0) rem = rem - 1;
        end
    endtask

    // Inputs change on the falling edge; outputs are read on the next falling edge
    task automatic cyc(bit v, bit m);
        rs_valid = v;
        rs_miss  = m;
        @(negedge clk);
        model_step(v, m);
    endtask

    task automatic do_reset();
        rst      = 1'b1;
        rs_valid = 1'b0;
        rs_miss  = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        mm  = 0;
        rem = 0;
    endtask

    task automatic cmp(string req);
        check(fetch_en == (rem == 0), req, "fetch_en vs model", int'(fetch_en), int'(rem == 0));
        check(gating == (rem != 0), req, "gating vs model", int'(gating), int'(rem != 0));
    endtask

    initial begin
        int off;
        @(negedge clk);
        do_reset();
        // R1: state right after reset
        check(fetch_en == 1'b1, "R1", "fetch_en after reset", int'(fetch_en), 1);
        check(gating == 1'b0, "R1", "gating after reset", int'(gating), 0);

        // Table walk: bursts of misses against threshold and hold length
        for (int i = 0; i < 12; i++) begin
            do_reset();
            thr = TBL[i][0][CW-1:0];
            len = TBL[i][1][LW-1:0];
            off = 0;
            for (int b = 0; b < TBL[i][2]; b++) begin
                cyc(1'b1, 1'b1);
                off += int'(!fetch_en);
                check(gating == !fetch_en, "R9", "gating flag", int'(gating), int'(!fetch_en));
            end
            for (int w = 0; w < 40; w++) begin
                cyc(1'b0, 1'b0);
                off += int'(!fetch_en);
            end
            check(off == TBL[i][3], "R3/R4/R7/R8", "fetch-off cycles for table row", off, TBL[i][3]);
        end

        // R1: reset in the middle of a hold ends it and clears the count
        do_reset();
        thr = 0; len = 10;
        cyc(1'b1, 1'b1);
        check(fetch_en == 1'b0, "R3", "fetch_en after crossing miss", int'(fetch_en), 0);
        do_reset();
        check(fetch_en == 1'b1, "R1", "fetch_en after reset during hold", int'(fetch_en), 1);
        thr = 1; len = 3;
        cyc(1'b1, 1'b1);
        check(fetch_en == 1'b1, "R1", "count cleared by reset", int'(fetch_en), 1);

        // R2: hits and misses without valid are not counted
        do_reset();
        thr = 2; len = 3;
        cyc(1'b1, 1'b1);
        for (int h = 0; h < 5; h++) cyc(1'b1, 1'b0);
        for (int h = 0; h < 3; h++) cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b1);
        check(fetch_en == 1'b1, "R2", "no hold after two real misses", int'(fetch_en), 1);
        cyc(1'b1, 1'b1);
        check(fetch_en == 1'b0, "R3", "hold on third miss, next cycle", int'(fetch_en), 0);
        // R4: exact length 3
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b0);
        check(fetch_en == 1'b0, "R4", "still off in third hold cycle", int'(fetch_en), 0);
        cyc(1'b0, 1'b0);
        check(fetch_en == 1'b1, "R4", "fetch resumes after hold", int'(fetch_en), 1);
        // R5: count was cleared at start
        cyc(1'b1, 1'b1);
        cyc(1'b1, 1'b1);
        check(fetch_en == 1'b1, "R5", "two new misses do not retrigger", int'(fetch_en), 1);
        cyc(1'b1, 1'b1);
        check(fetch_en == 1'b0, "R5", "third new miss retriggers", int'(fetch_en), 0);

        // R6 and R11: misses in a hold are counted but do not extend it
        do_reset();
        thr = 1; len = 5;
        cyc(1'b1, 1'b1);
        cyc(1'b1, 1'b1);
        off = int'(!fetch_en);
        for (int h = 0; h < 3; h++) begin
            cyc(1'b1, 1'b1);
            off += int'(!fetch_en);
        end
        cyc(1'b0, 1'b0);
        off += int'(!fetch_en);
        cyc(1'b0, 1'b0);
        check(fetch_en == 1'b1, "R6", "hold not extended by misses", int'(fetch_en), 1);
        check(off == 5, "R6", "off cycles with misses inside hold", off, 5);
        cyc(1'b1, 1'b1);
        check(fetch_en == 1'b0, "R11", "leftover count retriggers at once", int'(fetch_en), 0);

        // R7: zero length never gates, counting continues
        do_reset();
        thr = 0; len = 0;
        off = 0;
        for (int h = 0; h < 10; h++) begin
            cyc(1'b1, 1'b1);
            off += int'(!fetch_en);
        end
        check(off == 0, "R7", "off cycles with zero length", off, 0);
        len = 2;
        cyc(1'b1, 1'b1);
        check(fetch_en == 1'b0, "R7", "count kept while disabled", int'(fetch_en), 0);

        // R8: saturation, maximum threshold never triggers, no wrap
        do_reset();
        thr = CW'(CMAX); len = 4;
        off = 0;
        for (int h = 0; h < 20; h++) begin
            cyc(1'b1, 1'b1);
            off += int'(!fetch_en);
        end
        check(off == 0, "R8", "off cycles at maximum threshold", off, 0);
        thr = CW'(CMAX - 1);
        cyc(1'b1, 1'b1);
        check(fetch_en == 1'b0, "R8", "saturated count exceeds max-1", int'(fetch_en), 0);

        // R10: length change during a hold has no effect
        do_reset();
        thr = 0; len = 4;
        cyc(1'b1, 1'b1);
        off = int'(!fetch_en);
        len = 20;
        for (int h = 0; h < 30; h++) begin
            cyc(1'b0, 1'b0);
            off += int'(!fetch_en);
        end
        check(off == 4, "R10", "hold length captured at start", off, 4);

        // Random resolve and mispredict traffic against the model
        for (int s = 0; s < 4; s++) begin
            do_reset();
            thr = CW'($urandom % 6);
            len = LW'($urandom % 13);
            for (int c = 0; c < 3000; c++) begin
                if (c % 37 == 0) begin
                    thr = CW'($urandom % 6);
                    len = LW'($urandom % 13);
                end
                cyc(($urandom % 4) != 0, ($urandom % 2) != 0);
                cmp("R3 R4 R6");
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R4 watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule